// File: doc/BRIEF.md
# Floating-Point Structural Hazard Tracker

This block sits at the issue stage of an in-order core and decides, each cycle, whether the floating-point instruction that is presented may issue. It has no view of registers or operand values. It knows only which execution resource each instruction class occupies, and for how many cycles. There are three such resources: the multiply pipe, the add pipe and the divide/square-root unit.

Each resource has its own down-counter. The counter loads when an instruction that needs the resource is granted. It then counts down by one each cycle. A request for a resource whose counter is nonzero is stalled. Requests for other resources are unaffected. Because of this, additions, divides and transfers can issue in the gaps of a long double-precision multiply, and a divide can run to completion while other floating-point work continues. The issue logic holds a stalled request steady until it is granted.

Top module: `fp_occupancy_tracker`

## Requirements
- R1: After synchronous active-low reset, all three busy outputs are 0, and the first request for any class is granted at once.
- R2: `issue_grant` is 1 exactly when `issue_valid` is 1 and the resource needed by `issue_class` is free. `issue_stall` is `issue_valid & ~issue_grant`. With `issue_valid` at 0, both are 0. The class encoding is: 0 add/compare/copy/convert, 1 constant load, 2 single multiply, 3 single multiply-accumulate, 4 double multiply, 5 double multiply-accumulate, 6 double fused multiply-add, 7 SIMD multiply, 8 single divide, 9 double divide. Codes 10 to 15 need no resource.
- R3: A granted class 4 or 5 occupies the multiply pipe for 4 cycles. A later multiply-pipe request is stalled for the 3 cycles after the issue cycle.
- R4: A granted class 6 occupies the multiply pipe for 5 cycles. Later multiply-pipe requests are stalled for 4 cycles.
- R5: A granted class 7 occupies the multiply pipe for 2 cycles. A later multiply-pipe request is stalled for 1 cycle.
- R6: Classes 2 and 3 occupy the multiply pipe for 1 cycle only, so multiply-pipe requests may issue back to back.
- R7: Classes 0 and 1 occupy the add pipe for 1 cycle only, so add-pipe requests may issue back to back.
- R8: While the multiply pipe is busy, add-pipe and divide requests are granted without delay. The multiply pipe's remaining hold is unchanged by them.
- R9: Class 8 occupies the divide unit for 14 cycles and class 9 for 29 cycles. Multiply-pipe and add-pipe requests are granted while the divider is busy.
- R10: Codes 10 to 15 are always granted when valid. They leave every busy output and every remaining hold unchanged.
- R11: A busy output is 1 exactly while its counter is nonzero. The counter falls by one per cycle, so after a single divide `div_busy` stays high for 13 cycles.
- R12: A stalled request does not load or extend any counter. The bench keeps a stalled request's valid and class stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | A floating-point instruction requests issue this cycle |
| issue_class | input | 4 | Class code of the requesting instruction (see R2) |
| issue_grant | output | 1 | The request issues this cycle |
| issue_stall | output | 1 | The request must be held and retried |
| mul_busy | output | 1 | Multiply pipe blocked for the next request |
| add_busy | output | 1 | Add pipe blocked for the next request |
| div_busy | output | 1 | Divide/square-root unit blocked for the next request |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. Grant and stall are never both high. A stall always coincides with a busy resource. A counter is only ever loaded from zero, and otherwise falls by exactly one per cycle. Requests that need no resource, or only the add pipe, are always granted. A stalled request stays stable. The exact hold length of each class, the interleaving of add and divide work inside a double multiply, and the immunity of the remaining hold to unrelated traffic depend on the decode table. Only the bench's scenarios show these, by counting stall cycles and busy cycles at the ports.

// File: rtl/fpot_pkg.sv
// Package: shared types for the floating-point occupancy tracker.
// Assumes a 4-bit class code; unlisted codes are treated as needing no resource.
package fpot_pkg;

    // Instruction class codes presented at the issue port.
    typedef enum logic [3:0] {
        FC_ADD      = 4'd0,
        FC_CONST    = 4'd1,
        FC_MUL_S    = 4'd2,
        FC_MAC_S    = 4'd3,
        FC_MUL_D    = 4'd4,
        FC_MAC_D    = 4'd5,
        FC_FMA_D    = 4'd6,
        FC_SIMD_MUL = 4'd7,
        FC_DIV_S    = 4'd8,
        FC_DIV_D    = 4'd9
    } fp_class_e;

    // Execution resource an instruction class occupies.
    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_ADD  = 2'd1,
        RS_MUL  = 2'd2,
        RS_DIV  = 2'd3
    } fp_res_e;

    localparam int NUM_RES   = 3;
    localparam int IDX_ADD   = 0;
    localparam int IDX_MUL   = 1;
    localparam int IDX_DIV   = 2;

endpackage

// File: rtl/fpot_decode.sv
// Module: maps an instruction class code onto the resource it needs and the
// number of cycles (issue cycle included) it keeps that resource.
// Assumes every hold parameter is at least 1 and fits in CNT_W bits.
module fpot_decode
    import fpot_pkg::*;
#(
    parameter int CNT_W         = 5,
    parameter int ADD_HOLD      = 1,
    parameter int MUL_SP_HOLD   = 1,
    parameter int MUL_DP_HOLD   = 4,
    parameter int FMA_DP_HOLD   = 5,
    parameter int SIMD_MUL_HOLD = 2,
    parameter int DIV_SP_HOLD   = 14,
    parameter int DIV_DP_HOLD   = 29
) (
    input  logic [3:0]       cls,
    output fp_res_e          res,
    output logic [CNT_W-1:0] hold
);

    // Class table lookup: resource and occupancy length.
    always_comb begin
        res  = RS_NONE;
        hold = '0;
        case (cls)
            FC_ADD, FC_CONST: begin
                res  = RS_ADD;
                hold = CNT_W'(ADD_HOLD);
            end
            FC_MUL_S, FC_MAC_S: begin
                res  = RS_MUL;
                hold = CNT_W'(MUL_SP_HOLD);
            end
            FC_MUL_D, FC_MAC_D: begin
                res  = RS_MUL;
                hold = CNT_W'(MUL_DP_HOLD);
            end
            FC_FMA_D: begin
                res  = RS_MUL;
                hold = CNT_W'(FMA_DP_HOLD);
            end
            FC_SIMD_MUL: begin
                res  = RS_MUL;
                hold = CNT_W'(SIMD_MUL_HOLD);
            end
            FC_DIV_S: begin
                res  = RS_DIV;
                hold = CNT_W'(DIV_SP_HOLD);
            end
            FC_DIV_D: begin
                res  = RS_DIV;
                hold = CNT_W'(DIV_DP_HOLD);
            end
            default: begin
                res  = RS_NONE;
                hold = '0;
            end
        endcase
    end

endmodule

// File: rtl/fpot_busy_counter.sv
// Module: one resource's occupancy down-counter. It loads the remaining
// blocked cycles on a grant and falls by one each cycle down to zero.
// Assumes load is only raised when the counter is already zero.
module fpot_busy_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] remain;

    // Count register: load on grant, otherwise decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - CNT_W'(1);
    end

    // Busy flag: resource blocked while cycles remain.
    always_comb busy = (remain != '0);

    // R12: a grant only ever reaches an idle resource
    assert_load_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (remain == '0));

    // R11: an unloaded counter falls by exactly one per cycle
    assert_countdown_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0 && !load) |=> (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/fp_occupancy_tracker.sv
// Module: issue-stage structural hazard check for the floating-point
// resources of an in-order core. It grants a request when the resource its
// class needs is idle, and starts that resource's occupancy counter.
// Assumes one request per cycle, held stable by the issuer while stalled.
module fp_occupancy_tracker
    import fpot_pkg::*;
#(
    parameter int ADD_HOLD      = 1,
    parameter int MUL_SP_HOLD   = 1,
    parameter int MUL_DP_HOLD   = 4,
    parameter int FMA_DP_HOLD   = 5,
    parameter int SIMD_MUL_HOLD = 2,
    parameter int DIV_SP_HOLD   = 14,
    parameter int DIV_DP_HOLD   = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_valid,
    input  logic [3:0] issue_class,
    output logic       issue_grant,
    output logic       issue_stall,
    output logic       mul_busy,
    output logic       add_busy,
    output logic       div_busy
);

    localparam int MAX_A    = (MUL_DP_HOLD > FMA_DP_HOLD) ? MUL_DP_HOLD : FMA_DP_HOLD;
    localparam int MAX_B    = (DIV_SP_HOLD > DIV_DP_HOLD) ? DIV_SP_HOLD : DIV_DP_HOLD;
    localparam int MAX_HOLD = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_HOLD + 1);

    fp_res_e            need_res;
    logic [CNT_W-1:0]   need_hold;
    logic [CNT_W-1:0]   load_val;
    logic [NUM_RES-1:0] busy_vec;
    logic [NUM_RES-1:0] load_vec;
    logic               res_free;

    fpot_decode #(
        .CNT_W        (CNT_W),
        .ADD_HOLD     (ADD_HOLD),
        .MUL_SP_HOLD  (MUL_SP_HOLD),
        .MUL_DP_HOLD  (MUL_DP_HOLD),
        .FMA_DP_HOLD  (FMA_DP_HOLD),
        .SIMD_MUL_HOLD(SIMD_MUL_HOLD),
        .DIV_SP_HOLD  (DIV_SP_HOLD),
        .DIV_DP_HOLD  (DIV_DP_HOLD)
    ) u_decode (
        .cls (issue_class),
        .res (need_res),
        .hold(need_hold)
    );

    // Free check: is the resource needed by this class idle now.
    always_comb begin
        case (need_res)
            RS_ADD:  res_free = !busy_vec[IDX_ADD];
            RS_MUL:  res_free = !busy_vec[IDX_MUL];
            RS_DIV:  res_free = !busy_vec[IDX_DIV];
            default: res_free = 1'b1;
        endcase
    end

    // Issue decision: grant or stall the presented request.
    always_comb begin
        issue_grant = issue_valid && res_free;
        issue_stall = issue_valid && !res_free;
    end

    // Cycles still blocked after the issue cycle.
    always_comb load_val = need_hold - CNT_W'(1);

    // Load steering: only the granted class's resource counter loads.
    always_comb begin
        load_vec          = '0;
        load_vec[IDX_ADD] = issue_grant && (need_res == RS_ADD);
        load_vec[IDX_MUL] = issue_grant && (need_res == RS_MUL);
        load_vec[IDX_DIV] = issue_grant && (need_res == RS_DIV);
    end

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        fpot_busy_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_vec[g]),
            .load_val(load_val),
            .busy    (busy_vec[g])
        );
    end

    // Busy outputs: one flag per resource.
    always_comb begin
        add_busy = busy_vec[IDX_ADD];
        mul_busy = busy_vec[IDX_MUL];
        div_busy = busy_vec[IDX_DIV];
    end

    // R2: grant and stall never coincide
    assert_grant_stall_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_grant && issue_stall));

    // R2: a stall is always explained by a busy resource
    assert_stall_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> (busy_vec != '0));

    // R10: classes that need no resource always issue
    assert_free_class_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class >= 4'd10) |-> issue_grant);

    // R7: add-pipe requests never wait with single-cycle holds
    assert_add_never_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class <= 4'd1) |-> issue_grant);

    // R12: a stalled request is held steady into the next cycle
    assert_stall_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |=> (issue_valid && $stable(issue_class)));

endmodule

// File: tb/fp_occupancy_tracker_test.sv
module fp_occupancy_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [3:0] issue_class = 4'd0;
    logic       issue_grant, issue_stall, mul_busy, add_busy, div_busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_occupancy_tracker uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_class(issue_class), .issue_grant(issue_grant),
        .issue_stall(issue_stall), .mul_busy(mul_busy),
        .add_busy(add_busy), .div_busy(div_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Present a class until granted; report the number of stalled cycles.
    task automatic request_until_grant(input logic [3:0] cls, output int stalls);
        stalls = 0;
        forever begin
            @(negedge clk);
            issue_valid = 1'b1;
            issue_class = cls;
            #1;
            if (issue_grant) break;
            stalls++;
            if (stalls > 100) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
        end
    endtask

    // First op then a probe op; compare probe stalls with the expected hold.
    task automatic hold_pair(input logic [3:0] first, input logic [3:0] probe,
                             input int exp_stalls, input string req);
        int s;
        request_until_grant(first, s);
        check(s == 0, req, s, 0);
        request_until_grant(probe, s);
        check(s == exp_stalls, req, s, exp_stalls);
        idle(32);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check(!mul_busy && !add_busy && !div_busy, "R1",
              {mul_busy, add_busy, div_busy}, 0);
        check(!issue_grant && !issue_stall, "R2", {issue_grant, issue_stall}, 0);
    endtask

    task automatic t_idle_while_busy();
        int s;
        request_until_grant(4'd4, s);
        @(negedge clk);
        issue_valid = 1'b0;
        issue_class = 4'd2;
        #1;
        check(!issue_grant && !issue_stall && mul_busy, "R2",
              {issue_grant, issue_stall, mul_busy}, 1);
        idle(10);
    endtask

    task automatic t_interleave_mul();
        int s;
        request_until_grant(4'd4, s);
        request_until_grant(4'd0, s);
        check(s == 0, "R8 add during mul", s, 0);
        request_until_grant(4'd8, s);
        check(s == 0, "R8 div during mul", s, 0);
        check(mul_busy == 1'b1, "R8 mul still busy", mul_busy, 1);
        request_until_grant(4'd2, s);
        check(s == 1, "R8 mul hold unchanged", s, 1);
        idle(32);
    endtask

    task automatic t_div_overlap();
        int s;
        request_until_grant(4'd9, s);
        request_until_grant(4'd4, s);
        check(s == 0, "R9 mul during div", s, 0);
        request_until_grant(4'd1, s);
        check(s == 0, "R9 add during div", s, 0);
        request_until_grant(4'd8, s);
        check(s == 26, "R9 double divide hold", s, 26);
        idle(32);
    endtask

    task automatic t_free_class();
        int s;
        request_until_grant(4'd5, s);
        request_until_grant(4'd12, s);
        check(s == 0, "R10 free class grant", s, 0);
        check(!div_busy && !add_busy, "R10 no side effect", {div_busy, add_busy}, 0);
        request_until_grant(4'd3, s);
        check(s == 2, "R10 mul hold unchanged", s, 2);
        request_until_grant(4'd15, s);
        check(s == 0 && !mul_busy, "R10 code 15", s, 0);
        idle(8);
    endtask

    task automatic t_busy_length();
        int s;
        int n = 0;
        request_until_grant(4'd8, s);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            #1;
            if (div_busy) n++;
        end
        check(n == 13, "R11 div busy cycles", n, 13);
    endtask

    task automatic t_stall_no_reload();
        int s;
        request_until_grant(4'd6, s);
        request_until_grant(4'd7, s);
        check(s == 4, "R12 stalled simd", s, 4);
        request_until_grant(4'd2, s);
        check(s == 1, "R12 hold from granted simd only", s, 1);
        idle(10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        hold_pair(4'd4, 4'd5, 3, "R3 mul_d then mac_d");
        hold_pair(4'd5, 4'd2, 3, "R3 mac_d then mul_s");
        hold_pair(4'd6, 4'd2, 4, "R4 fma_d");
        hold_pair(4'd7, 4'd2, 1, "R5 simd mul");
        hold_pair(4'd2, 4'd3, 0, "R6 single mul back to back");
        hold_pair(4'd0, 4'd1, 0, "R7 add then const");
        hold_pair(4'd8, 4'd9, 13, "R9 single divide hold");
        hold_pair(4'd9, 4'd9, 28, "R9 double divide hold");
        t_idle_while_busy();
        t_interleave_mul();
        t_div_overlap();
        t_free_class();
        t_busy_length();
        t_stall_no_reload();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", cycles, 20000);
            finish_run();
        end
    end

endmodule